// File: doc/BRIEF.md
# Burst Address Generator with Bank Rollover

This block turns one start command into a stream of memory addresses, one per clock. A start pulse latches a bank, a row and a column together with a burst mode. From the next cycle on, the block presents one beat per cycle on its outputs: bank, row and column, marked by a beat-valid strobe. Short bursts of one, two, four or eight beats stay inside an aligned column block and follow either a wrapping sequential order or an XOR (interleaved) order. Full-page mode steps through the columns without end, wrapping inside the same row.

Streaming mode is meant for long serial buffers. In this mode the column runs upward from the start column to the last column. It then moves to the next bank and starts again at the start column. When the bank number wraps from the highest bank back to bank 0, the row advances by one, and the row itself wraps to 0 after the last row. A stop pulse, which models a precharge of all banks, ends every kind of burst. A fixed-length burst also ends by itself after its last beat. The geometry is 4 banks, 1536 rows and 256 columns by default. The data path is not part of this block.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, and before any start pulse, beat_valid is low.
- R2: When start is sampled high and stop is low on a rising edge, beat_valid is high in the following cycle. That first beat carries the sampled start_bank, start_row and start_col.
- R3: burst_mode codes are 0 for one beat, 1 for two, 2 for four, 3 for eight, 4 for full page and 5 for streaming. With burst_interleave low, beat i of a fixed burst of length L keeps the column bits above the low log2(L) bits, and sets the low bits to (start low bits + i) mod L.
- R4: With burst_interleave high and a length of four or eight, the low bits of beat i are the start low bits XOR i. For lengths one and two, the order is the same as in R3.
- R5: A fixed burst of length L keeps beat_valid high for exactly L cycles, then drops it. Bank and row stay at their start values throughout.
- R6: In full-page mode (code 4) the column rises by one each cycle and wraps from 255 to 0, with bank and row unchanged, until stop. burst_interleave has no effect in this mode.
- R7: In streaming mode (code 5), the beat after column 255 carries the next bank (bank code plus one, modulo 4) and the start column again. When the bank wraps from 3 to 0, the row rises by one, and row 1535 is followed by row 0. burst_interleave has no effect in this mode.
- R8: A stop pulse makes beat_valid low from the next cycle, whatever the mode. When stop and start arrive in the same cycle, stop wins.
- R9: A start pulse during an active burst abandons that burst. The next cycle shows the first beat of the new burst.
- R10: The unused burst_mode codes 6 and 7 behave as a single-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch the start address and mode, then begin a burst |
| stop | input | 1 | End any burst (precharge of all banks) |
| burst_mode | input | 3 | Burst length or streaming selection, codes as in R3 |
| burst_interleave | input | 1 | Select XOR order for lengths four and eight |
| start_bank | input | 2 | Bank of the first beat |
| start_row | input | 11 | Row of the first beat |
| start_col | input | 8 | Column of the first beat |
| beat_valid | output | 1 | High for each cycle that carries a beat |
| beat_bank | output | 2 | Bank of the current beat |
| beat_row | output | 11 | Row of the current beat |
| beat_col | output | 8 | Column of the current beat |

## Verification
All outputs come straight from the beat registers, so a wrong beat index or a wrong latched start column shows up as a wrong beat_col in the same cycle it occurs. A wrong rollover decision in the bank or row step shows up one cycle after column 255 as a bank or row that disagrees with the model. A miscounted burst end shows up as beat_valid staying high one cycle too long or dropping one cycle too early. A mishandled stop is seen in the very next cycle.

// File: rtl/bag_pkg.sv
package bag_pkg;

  typedef enum logic [2:0] {
    BM_ONE     = 3'd0,
    BM_TWO     = 3'd1,
    BM_FOUR    = 3'd2,
    BM_EIGHT   = 3'd3,
    BM_FULL    = 3'd4,
    BM_STREAM  = 3'd5,
    BM_RSV6    = 3'd6,
    BM_RSV7    = 3'd7
  } bmode_e;

  // true for modes that run until stopped
  function automatic logic mode_is_endless(bmode_e m);
    return (m == BM_FULL) || (m == BM_STREAM);
  endfunction

  // XOR ordering only applies to four- and eight-beat bursts
  function automatic logic mode_takes_xor(bmode_e m, logic ilv);
    return ilv && ((m == BM_FOUR) || (m == BM_EIGHT));
  endfunction

endpackage

// File: rtl/bag_col_order.sv
module bag_col_order
  import bag_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  bmode_e           mode,
  input  logic             ilv,
  input  logic [COL_W-1:0] scol,
  input  logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] col,
  output logic             last_fixed,
  output logic             col_end
);

  // bits of the column that move during one burst
  function automatic logic [COL_W-1:0] span_mask(bmode_e m);
    logic [COL_W-1:0] r;
    case (m)
      BM_TWO:              r = COL_W'(1);
      BM_FOUR:             r = COL_W'(3);
      BM_EIGHT:            r = COL_W'(7);
      BM_FULL, BM_STREAM:  r = '1;
      default:             r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [COL_W-1:0] order_col(bmode_e m, logic x,
                                                 logic [COL_W-1:0] s,
                                                 logic [COL_W-1:0] i);
    logic [COL_W-1:0] msk;
    logic [COL_W-1:0] low;
    msk = span_mask(m);
    low = mode_takes_xor(m, x) ? (s ^ i) : (s + i);
    return (s & ~msk) | (low & msk);
  endfunction

  logic [COL_W-1:0] mask_w;

  assign mask_w     = span_mask(mode);
  assign col        = order_col(mode, ilv, scol, idx);
  assign last_fixed = !mode_is_endless(mode) && (idx == mask_w);
  assign col_end    = (col == '1);

endmodule

// File: rtl/bag_page_step.sv
module bag_page_step #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 11,
  parameter int ROWS   = 1536
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  output logic [BANK_W-1:0] nbank,
  output logic [ROW_W-1:0]  nrow
);

  function automatic logic [ROW_W-1:0] row_after(logic [ROW_W-1:0] r);
    return (r == ROW_W'(ROWS - 1)) ? '0 : r + 1'b1;
  endfunction

  assign nbank = bank + 1'b1;
  assign nrow  = (bank == '1) ? row_after(row) : row;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROWS  = 1536,
  parameter int COLS  = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     stop,
  input  logic [2:0]               burst_mode,
  input  logic                     burst_interleave,
  input  logic [$clog2(BANKS)-1:0] start_bank,
  input  logic [$clog2(ROWS)-1:0]  start_row,
  input  logic [$clog2(COLS)-1:0]  start_col,
  output logic                     beat_valid,
  output logic [$clog2(BANKS)-1:0] beat_bank,
  output logic [$clog2(ROWS)-1:0]  beat_row,
  output logic [$clog2(COLS)-1:0]  beat_col
);

  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(COLS);

  logic              act_q;
  bmode_e            mode_q;
  logic              ilv_q;
  logic [COL_W-1:0]  scol_q;
  logic [COL_W-1:0]  idx_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;

  // named events for the checks below
  logic              last_fixed;
  logic              col_end;
  logic [COL_W-1:0]  cur_col;
  logic [BANK_W-1:0] next_bank;
  logic [ROW_W-1:0]  next_row;

  bag_col_order #(.COL_W(COL_W)) u_order (
    .mode       (mode_q),
    .ilv        (ilv_q),
    .scol       (scol_q),
    .idx        (idx_q),
    .col        (cur_col),
    .last_fixed (last_fixed),
    .col_end    (col_end)
  );

  bag_page_step #(.BANK_W(BANK_W), .ROW_W(ROW_W), .ROWS(ROWS)) u_step (
    .bank  (bank_q),
    .row   (row_q),
    .nbank (next_bank),
    .nrow  (next_row)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      mode_q <= BM_ONE;
      ilv_q  <= 1'b0;
      scol_q <= '0;
      idx_q  <= '0;
      bank_q <= '0;
      row_q  <= '0;
    end else if (stop) begin
      act_q <= 1'b0;
    end else if (start) begin
      act_q  <= 1'b1;
      mode_q <= bmode_e'(burst_mode);
      ilv_q  <= burst_interleave;
      scol_q <= start_col;
      idx_q  <= '0;
      bank_q <= start_bank;
      row_q  <= start_row;
    end else if (act_q) begin
      if (mode_q == BM_STREAM) begin
        if (col_end) begin
          idx_q  <= '0;
          bank_q <= next_bank;
          row_q  <= next_row;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else if (mode_q == BM_FULL) begin
        idx_q <= idx_q + 1'b1;
      end else if (last_fixed) begin
        act_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign beat_valid = act_q;
  assign beat_bank  = bank_q;
  assign beat_row   = row_q;
  assign beat_col   = cur_col;

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> (beat_valid && beat_col == $past(start_col)
                          && beat_bank == $past(start_bank)
                          && beat_row == $past(start_row)));

  assert_burst_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && last_fixed && !stop && !start) |=> !beat_valid);

  assert_page_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && mode_q == BM_FULL && beat_col == '1 && !stop && !start)
      |=> (beat_valid && beat_col == '0 && $stable(beat_bank) && $stable(beat_row)));

  assert_bank_roll_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && mode_q == BM_STREAM && col_end && !stop && !start)
      |=> (beat_valid && beat_bank == BANK_W'($past(beat_bank) + 1'b1)
           && beat_col == scol_q));

  assert_stop_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !beat_valid);

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic [2:0]  burst_mode = 3'd0;
  logic        burst_interleave = 1'b0;
  logic [1:0]  start_bank = '0;
  logic [10:0] start_row = '0;
  logic [7:0]  start_col = '0;
  logic        beat_valid;
  logic [1:0]  beat_bank;
  logic [10:0] beat_row;
  logic [7:0]  beat_col;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen i_burst_addr_gen (
    .clk, .rst_n, .start, .stop, .burst_mode, .burst_interleave,
    .start_bank, .start_row, .start_col,
    .beat_valid, .beat_bank, .beat_row, .beat_col
  );

  // expected column, restated from the ordering rules
  function automatic int exp_col(int mode, bit ilv, int scol, int i);
    int len;
    int base;
    int off;
    if (mode == 4 || mode == 5) return (scol + i) % 256;
    case (mode)
      1: len = 2;
      2: len = 4;
      3: len = 8;
      default: len = 1;
    endcase
    base = scol - (scol % len);
    off  = scol % len;
    if (ilv && len >= 4) off = off ^ i;
    else off = (off + i) % len;
    return base + off;
  endfunction

  task automatic check_beat(string req, int eb, int er, int ec);
    n_chk++;
    if (!(beat_valid === 1'b1 && beat_bank == eb[1:0] && beat_row == er[10:0]
          && beat_col == ec[7:0])) begin
      n_bad++;
      $display("FAIL %s: got v=%0b b=%0d r=%0d c=%0h, expected v=1 b=%0d r=%0d c=%0h",
               req, beat_valid, beat_bank, beat_row, beat_col, eb, er, ec);
    end
  endtask

  task automatic check_idle(string req);
    n_chk++;
    if (beat_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: got beat_valid=%0b, expected 0", req, beat_valid);
    end
  endtask

  // drive a start at a falling edge; returns at the falling edge showing beat 0
  task automatic launch(int mode, bit ilv, int b, int r, int c);
    burst_mode = mode[2:0];
    burst_interleave = ilv;
    start_bank = b[1:0];
    start_row = r[10:0];
    start_col = c[7:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  // fixed-length burst: every beat then idle
  task automatic run_fixed(string req, int mode, bit ilv, int len, int scol);
    @(negedge clk);
    launch(mode, ilv, 1, 77, scol);
    for (int i = 0; i < len; i++) begin
      check_beat(req, 1, 77, exp_col(mode, ilv, scol, i));
      @(negedge clk);
    end
    check_idle({req, " end (R5)"});
  endtask

  task automatic t_reset();
    check_idle("R1 reset");
  endtask

  task automatic t_sequential();
    run_fixed("R3 seq BL4", 2, 1'b0, 4, 8'h11);
    run_fixed("R3 seq BL8", 3, 1'b0, 8, 8'h2E);
    run_fixed("R3 seq BL2", 1, 1'b0, 2, 8'h33);
    run_fixed("R5 BL1", 0, 1'b0, 1, 8'h9A);
  endtask

  task automatic t_interleave();
    run_fixed("R4 ilv BL8", 3, 1'b1, 8, 8'h25);
    run_fixed("R4 ilv BL4", 2, 1'b1, 4, 8'h53);
    run_fixed("R4 ilv BL2", 1, 1'b1, 2, 8'h61);
  endtask

  task automatic t_full_page();
    @(negedge clk);
    launch(4, 1'b1, 2, 300, 8'hFD);
    for (int i = 0; i < 6; i++) begin
      check_beat("R6 full page wrap", 2, 300, (8'hFD + i) % 256);
      @(negedge clk);
    end
    pulse_stop();
    check_idle("R8 stop full page");
  endtask

  task automatic t_stream();
    int eb;
    int er;
    int cols [2];
    cols[0] = 8'hFE;
    cols[1] = 8'hFF;
    @(negedge clk);
    launch(5, 1'b1, 2, 1535, 8'hFE);
    eb = 2;
    er = 1535;
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 2; j++) begin
        check_beat("R7 stream roll", eb, er, cols[j]);
        @(negedge clk);
      end
      eb = (eb + 1) % 4;
      if (eb == 0) er = (er + 1) % 1536;
    end
    pulse_stop();
    check_idle("R8 stop stream");
  endtask

  task automatic t_stop_early();
    @(negedge clk);
    launch(3, 1'b0, 0, 9, 8'h40);
    for (int i = 0; i < 3; i++) begin
      check_beat("R8 pre-stop beats", 0, 9, 8'h40 + i);
      @(negedge clk);
    end
    pulse_stop();
    check_idle("R8 stop mid burst");
    @(negedge clk);
    check_idle("R8 stays idle");
  endtask

  task automatic t_stop_with_start();
    @(negedge clk);
    start_col = 8'h10;
    burst_mode = 3'd2;
    start = 1'b1;
    stop = 1'b1;
    @(negedge clk);
    start = 1'b0;
    stop = 1'b0;
    check_idle("R8 stop beats start");
  endtask

  task automatic t_restart();
    @(negedge clk);
    launch(3, 1'b0, 0, 5, 8'h08);
    for (int i = 0; i < 2; i++) begin
      check_beat("R9 first burst", 0, 5, 8'h08 + i);
      @(negedge clk);
    end
    launch(2, 1'b0, 3, 12, 8'h42);
    for (int i = 0; i < 4; i++) begin
      check_beat("R9 replacing burst", 3, 12, exp_col(2, 1'b0, 8'h42, i));
      @(negedge clk);
    end
    check_idle("R9 replacing burst end");
  endtask

  task automatic t_reserved();
    run_fixed("R10 code 6", 6, 1'b0, 1, 8'h77);
    run_fixed("R10 code 7", 7, 1'b1, 1, 8'h13);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset release");
    t_sequential();
    t_interleave();
    t_full_page();
    t_stream();
    t_stop_early();
    t_stop_with_start();
    t_restart();
    t_reserved();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule